// File: doc/BRIEF.md
# Banked Interrupt Event Unit

This block gathers a configurable number of level-sensitive interrupt lines and presents them to one core through a 32-bit register port. Each line has a mask bit and a software-pending bit. Both are stored in 32-line banks and change only through write-one-to-set and write-one-to-clear register pairs. A line asks for service when its external input or its software-pending bit is high and its mask bit is low. The `irq_out` output stays high while at least one line asks for service.

Software services an interrupt by reading the event register. That read is destructive. It returns the die number, the event type and the number of the lowest-numbered requesting line. In the same cycle it sets that line's mask bit, so the line stays silent until software unmasks it. The register port also provides a read-only info word, a core-identity word taken from the requesting core's number, and one destination-core register per line.

Top module: `intc_event_unit`

## Requirements
- R1: After reset, every mask bit reads 1, every software-pending bit reads 0, and `irq_out` is low even when external inputs are high.
- R2: A read of offset 0x0004 returns the line count in bits 15:0 and the die count minus one in bits 27:24. All other bits read 0.
- R3: Writing 1 to a bit at 0x4100 + 4*bank sets that line's mask bit. Writing 1 to a bit at 0x4180 + 4*bank clears it. Zero bits leave the state unchanged. Line n is bank n/32, bit n%32. A read of either address returns the current mask word.
- R4: Software-pending bits behave the same way. Set is at 0x4000 + 4*bank and clear is at 0x4080 + 4*bank, and a read of either address returns the current pending word.
- R5: A line requests service when (external input OR software-pending) AND NOT mask. `irq_out` is high exactly when some line requests service.
- R6: A read of 0x2004 while lines request service returns the lowest-numbered requesting line. The die number (0) is in bits 31:24, type 1 (external interrupt) is in bits 23:16 and the line number is in bits 15:0.
- R7: A read of 0x2004 that reports a line sets that line's mask bit. The next read then reports the next requesting line.
- R8: A read of 0x2004 with no requesting line returns 0 and changes no state.
- R9: The destination-core register of line n is at 0x3000 + 4*n. It is NUM_CORES bits wide, resets to 0 and reads back what was written. Writing 1 selects core 0.
- R10: A read of 0x2000 returns the `core_id` input, zero-extended.
- R11: Read data appears on `bus_rdata` with `bus_rvalid` high exactly one cycle after the read request. Unmapped offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_irq | input | NUM_LINES | Level interrupt inputs, bit n is line n |
| core_id | input | CORE_ID_W | Hardware number of the core issuing the access |
| bus_sel | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| irq_out | output | 1 | High while any line requests service |

## Verification
The hardest case to reach from the ports is two lines requesting service at once, with the lower one claimed and masked by an event read while the higher one keeps requesting. The claim order and the mask side effect only show up across successive destructive reads. The bench first unmasks whole banks. It then raises external lines in two different banks together with a software-pending bit in the top line. It reads the event register repeatedly and checks after each read which line came out, the mask words and `irq_out`, until the register reads 0.

// File: rtl/intc_pkg.sv
package intc_pkg;

  typedef enum logic [7:0] {
    EVT_NONE = 8'd0,
    EVT_EXT  = 8'd1,
    EVT_IPI  = 8'd4
  } evt_kind_e;

  typedef enum logic [1:0] {
    WIN_PEND_SET = 2'd0,
    WIN_PEND_CLR = 2'd1,
    WIN_MASK_SET = 2'd2,
    WIN_MASK_CLR = 2'd3
  } bank_win_e;

  localparam logic [15:0] OFS_INFO   = 16'h0004;
  localparam logic [15:0] OFS_WHOAMI = 16'h2000;
  localparam logic [15:0] OFS_EVENT  = 16'h2004;
  localparam logic [3:0]  PAGE_TGT   = 4'h3;
  localparam logic [6:0]  PAGE_BANKS = 7'h20;

  function automatic logic [31:0] evt_word(input logic [7:0] die,
                                           input evt_kind_e kind,
                                           input logic [15:0] num);
    return {die, kind, num};
  endfunction

  function automatic int bank_of(input int line);
    return line / 32;
  endfunction

  function automatic int bit_of(input int line);
    return line % 32;
  endfunction

  function automatic logic [31:0] info_word(input int lines, input int dies);
    logic [31:0] w;
    w = '0;
    w[15:0]  = 16'(lines);
    w[27:24] = 4'(dies - 1);
    return w;
  endfunction

endpackage

// File: rtl/intc_line_state.sv
module intc_line_state
  import intc_pkg::*;
#(
  parameter int NUM_LINES = 64,
  localparam int NB = (NUM_LINES + 31) / 32,
  localparam int BW = (NB > 1) ? $clog2(NB) : 1,
  localparam int LW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pend_set_we,
  input  logic                 pend_clr_we,
  input  logic                 mask_set_we,
  input  logic                 mask_clr_we,
  input  logic [BW-1:0]        bank_sel,
  input  logic [31:0]          wdata,
  input  logic                 claim,
  input  logic [LW-1:0]        claim_idx,
  input  logic [NUM_LINES-1:0] ext_irq,
  output logic [NB*32-1:0]     mask_flat,
  output logic [NB*32-1:0]     pend_flat,
  output logic [NUM_LINES-1:0] request
);

  logic [NUM_LINES-1:0] mask_q;
  logic [NUM_LINES-1:0] pend_q;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    localparam int BK = bank_of(i);
    localparam int BT = bit_of(i);
    logic hit_bank;
    logic hit_claim;
    assign hit_bank  = (bank_sel == BW'(BK)) && wdata[BT];
    assign hit_claim = claim && (claim_idx == LW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_q[i] <= 1'b1;
      end else if (mask_set_we && hit_bank) begin
        mask_q[i] <= 1'b1;
      end else if (mask_clr_we && hit_bank) begin
        mask_q[i] <= 1'b0;
      end else if (hit_claim) begin
        mask_q[i] <= 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q[i] <= 1'b0;
      end else if (pend_set_we && hit_bank) begin
        pend_q[i] <= 1'b1;
      end else if (pend_clr_we && hit_bank) begin
        pend_q[i] <= 1'b0;
      end
    end

    assign request[i] = (ext_irq[i] | pend_q[i]) & ~mask_q[i];
  end

  always_comb begin
    mask_flat = '0;
    pend_flat = '0;
    mask_flat[NUM_LINES-1:0] = mask_q;
    pend_flat[NUM_LINES-1:0] = pend_q;
  end

  AST_CLAIM_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    claim |=> mask_q[$past(claim_idx)]); // R7

  AST_ZERO_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ((mask_set_we || mask_clr_we) && wdata == 32'd0 && !claim) |=> $stable(mask_q)); // R3

  AST_ZERO_PEND_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_set_we || pend_clr_we) && wdata == 32'd0) |=> $stable(pend_q)); // R4

  AST_WRITE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pend_set_we, pend_clr_we, mask_set_we, mask_clr_we, claim})); // R3

endmodule

// File: rtl/intc_lowest_pick.sv
module intc_lowest_pick #(
  parameter int N = 64,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] req,
  output logic         found,
  output logic [W-1:0] idx
);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = W'(i);
      end
    end
  end

  always_comb begin
    if (found) begin
      AST_PICK_REQUESTING: assert (req[idx]); // R6
    end
  end

endmodule

// File: rtl/intc_target_regs.sv
module intc_target_regs #(
  parameter int NUM_LINES = 64,
  parameter int NUM_CORES = 4,
  localparam int LW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [LW-1:0]        idx,
  input  logic [31:0]          wdata,
  output logic [NUM_CORES-1:0] rd_val
);

  logic [NUM_CORES-1:0] tgt_q [NUM_LINES];

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_tgt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tgt_q[i] <= '0;
      end else if (we && idx == LW'(i)) begin
        tgt_q[i] <= wdata[NUM_CORES-1:0];
      end
    end
  end

  assign rd_val = tgt_q[idx];

  AST_TARGET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> tgt_q[$past(idx)] == $past(wdata[NUM_CORES-1:0])); // R9

endmodule

// File: rtl/intc_event_unit.sv
module intc_event_unit
  import intc_pkg::*;
#(
  parameter int NUM_LINES = 64,
  parameter int NUM_DIES  = 1,
  parameter int NUM_CORES = 4,
  parameter int CORE_ID_W = 5,
  localparam int NB = (NUM_LINES + 31) / 32,
  localparam int BW = (NB > 1) ? $clog2(NB) : 1,
  localparam int LW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] ext_irq,
  input  logic [CORE_ID_W-1:0] core_id,
  input  logic                 bus_sel,
  input  logic                 bus_we,
  input  logic [15:0]          bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic                 bus_rvalid,
  output logic                 irq_out
);

  // decode
  logic          rd_req, wr_req;
  logic          in_banks, bank_ok, in_tgt;
  bank_win_e     win;
  logic [BW-1:0] bank_sel;
  logic [LW-1:0] tgt_idx;

  assign rd_req   = bus_sel && !bus_we;
  assign wr_req   = bus_sel && bus_we;
  assign win      = bank_win_e'(bus_addr[8:7]);
  assign bank_sel = bus_addr[BW+1:2];
  assign bank_ok  = (32'(bus_addr[6:2]) < NB) && (bus_addr[1:0] == 2'b00);
  assign in_banks = (bus_addr[15:9] == PAGE_BANKS) && bank_ok;
  assign tgt_idx  = bus_addr[LW+1:2];
  assign in_tgt   = (bus_addr[15:12] == PAGE_TGT) && (bus_addr[1:0] == 2'b00)
                    && (32'(bus_addr[11:2]) < NUM_LINES);

  // named internal events
  logic pend_set_we, pend_clr_we, mask_set_we, mask_clr_we, tgt_we;
  logic rd_event, claim_fire;

  assign pend_set_we = wr_req && in_banks && win == WIN_PEND_SET;
  assign pend_clr_we = wr_req && in_banks && win == WIN_PEND_CLR;
  assign mask_set_we = wr_req && in_banks && win == WIN_MASK_SET;
  assign mask_clr_we = wr_req && in_banks && win == WIN_MASK_CLR;
  assign tgt_we      = wr_req && in_tgt;
  assign rd_event    = rd_req && bus_addr == OFS_EVENT;

  logic [NB*32-1:0]     mask_flat, pend_flat;
  logic [NUM_LINES-1:0] request;
  logic                 pick_found;
  logic [LW-1:0]        pick_idx;
  logic [NUM_CORES-1:0] tgt_val;

  assign claim_fire = rd_event && pick_found;

  intc_line_state #(.NUM_LINES(NUM_LINES)) u_state (
    .clk         (clk),
    .rst_n       (rst_n),
    .pend_set_we (pend_set_we),
    .pend_clr_we (pend_clr_we),
    .mask_set_we (mask_set_we),
    .mask_clr_we (mask_clr_we),
    .bank_sel    (bank_sel),
    .wdata       (bus_wdata),
    .claim       (claim_fire),
    .claim_idx   (pick_idx),
    .ext_irq     (ext_irq),
    .mask_flat   (mask_flat),
    .pend_flat   (pend_flat),
    .request     (request)
  );

  intc_lowest_pick #(.N(NUM_LINES)) u_pick (
    .req   (request),
    .found (pick_found),
    .idx   (pick_idx)
  );

  intc_target_regs #(.NUM_LINES(NUM_LINES), .NUM_CORES(NUM_CORES)) u_tgt (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (tgt_we),
    .idx    (tgt_idx),
    .wdata  (bus_wdata),
    .rd_val (tgt_val)
  );

  // bank word selection for readback
  logic [31:0] mask_word, pend_word;
  always_comb begin
    mask_word = '0;
    pend_word = '0;
    for (int b = 0; b < NB; b++) begin
      if (bank_sel == BW'(b)) begin
        mask_word = mask_flat[b*32 +: 32];
        pend_word = pend_flat[b*32 +: 32];
      end
    end
  end

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (bus_addr == OFS_INFO) begin
      rd_mux = info_word(NUM_LINES, NUM_DIES);
    end else if (bus_addr == OFS_WHOAMI) begin
      rd_mux = 32'(core_id);
    end else if (bus_addr == OFS_EVENT) begin
      rd_mux = pick_found ? evt_word(8'd0, EVT_EXT, 16'(pick_idx)) : 32'd0;
    end else if (in_tgt) begin
      rd_mux = 32'(tgt_val);
    end else if (in_banks) begin
      rd_mux = (win == WIN_MASK_SET || win == WIN_MASK_CLR) ? mask_word : pend_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd_req;
      if (rd_req) bus_rdata <= rd_mux;
    end
  end

  assign irq_out = pick_found;

  AST_EMPTY_EVENT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_event && !irq_out) |=> bus_rdata == 32'd0); // R8

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> bus_rvalid); // R11

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !bus_rvalid); // R11

  AST_IRQ_NEEDS_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (request != '0)); // R5

endmodule

// File: tb/tb_intc_event_unit.sv
module tb_intc_event_unit;

  localparam int NL = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [NL-1:0] ext_irq = '0;
  logic [4:0]  core_id = '0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        irq_out;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  intc_event_unit dut (
    .clk(clk), .rst_n(rst_n), .ext_irq(ext_irq), .core_id(core_id),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(posedge clk);
    #1;
    d = bus_rdata;
    chk("R11 rvalid", {31'd0, bus_rvalid}, 32'd1);
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  // address helpers restated from the requirements
  function automatic logic [15:0] a_pset(input int bank); return 16'(32'h4000 + 4*bank); endfunction
  function automatic logic [15:0] a_pclr(input int bank); return 16'(32'h4080 + 4*bank); endfunction
  function automatic logic [15:0] a_mset(input int bank); return 16'(32'h4100 + 4*bank); endfunction
  function automatic logic [15:0] a_mclr(input int bank); return 16'(32'h4180 + 4*bank); endfunction
  function automatic logic [31:0] ev(input int line); return 32'h0001_0000 | 32'(line); endfunction

  task automatic t_reset();
    logic [31:0] d;
    ext_irq = '1;
    #1;
    chk("R1 irq masked", {31'd0, irq_out}, 32'd0);
    rd(a_mset(0), d); chk("R1 mask bank0", d, 32'hFFFF_FFFF);
    rd(a_mclr(1), d); chk("R1 mask bank1", d, 32'hFFFF_FFFF);
    rd(a_pset(0), d); chk("R1 pend bank0", d, 32'd0);
    rd(a_pclr(1), d); chk("R1 pend bank1", d, 32'd0);
    rd(16'h2004, d);  chk("R8 empty event", d, 32'd0);
    ext_irq = '0;
  endtask

  task automatic t_info();
    logic [31:0] d;
    rd(16'h0004, d); chk("R2 info", d, 32'h0000_0040);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(a_mclr(0), 32'h5);
    rd(a_mset(0), d); chk("R3 clear bits", d, 32'hFFFF_FFFA);
    wr(a_mclr(0), 32'h0);
    wr(a_mset(0), 32'h0);
    rd(a_mclr(0), d); chk("R3 zero write", d, 32'hFFFF_FFFA);
    wr(a_mset(0), 32'h1);
    rd(a_mset(0), d); chk("R3 set bit", d, 32'hFFFF_FFFB);
    wr(a_mset(0), 32'h4);
  endtask

  task automatic t_pend();
    logic [31:0] d;
    wr(a_pset(1), 32'h8000_0001);
    rd(a_pset(1), d); chk("R4 set", d, 32'h8000_0001);
    wr(a_pclr(1), 32'h1);
    rd(a_pclr(1), d); chk("R4 clear", d, 32'h8000_0000);
    wr(a_pclr(1), 32'h0);
    rd(a_pset(1), d); chk("R4 zero write", d, 32'h8000_0000);
  endtask

  task automatic t_claim_single();
    logic [31:0] d;
    #1;
    chk("R5 masked pending no irq", {31'd0, irq_out}, 32'd0);
    wr(a_mclr(1), 32'h8000_0000);
    #1;
    chk("R5 unmasked irq", {31'd0, irq_out}, 32'd1);
    rd(16'h2004, d); chk("R6 event line 63", d, ev(63));
    #1;
    chk("R7 irq drops after claim", {31'd0, irq_out}, 32'd0);
    rd(a_mset(1), d); chk("R7 line 63 remasked", d, 32'hFFFF_FFFF);
    rd(a_pset(1), d); chk("R8 pend kept", d, 32'h8000_0000);
  endtask

  task automatic t_order();
    logic [31:0] d;
    wr(a_mclr(0), 32'hFFFF_FFFF);
    wr(a_mclr(1), 32'hFFFF_FFFF);
    @(negedge clk);
    ext_irq[40] = 1'b1; ext_irq[5] = 1'b1;
    #1;
    chk("R5 ext irq", {31'd0, irq_out}, 32'd1);
    rd(16'h2004, d); chk("R6 lowest first", d, ev(5));
    rd(a_mset(0), d); chk("R7 line 5 masked", d, 32'h0000_0020);
    rd(16'h2004, d); chk("R7 next line 40", d, ev(40));
    rd(16'h2004, d); chk("R6 soft line 63", d, ev(63));
    rd(16'h2004, d); chk("R8 empty after drain", d, 32'd0);
    rd(a_mset(1), d); chk("R8 no extra mask", d, 32'h8000_0100);
    #1;
    chk("R5 irq low", {31'd0, irq_out}, 32'd0);
    ext_irq = '0;
    wr(a_mclr(0), 32'h20);
    #1;
    chk("R5 level gone no irq", {31'd0, irq_out}, 32'd0);
  endtask

  task automatic t_target();
    logic [31:0] d;
    rd(16'h3000 + 16'd40, d); chk("R9 reset target", d, 32'd0);
    wr(16'h3000 + 16'd40, 32'h1);
    rd(16'h3000 + 16'd40, d); chk("R9 core0", d, 32'h1);
    wr(16'h30FC, 32'hFF);
    rd(16'h30FC, d); chk("R9 width", d, 32'hF);
    rd(16'h3000 + 16'd40, d); chk("R9 neighbour kept", d, 32'h1);
  endtask

  task automatic t_misc();
    logic [31:0] d;
    core_id = 5'd7;
    rd(16'h2000, d); chk("R10 core id", d, 32'd7);
    rd(16'h1000, d); chk("R11 unmapped", d, 32'd0);
    @(posedge clk); #1;
    chk("R11 rvalid single", {31'd0, bus_rvalid}, 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_info();
    t_mask();
    t_pend();
    t_claim_single();
    t_order();
    t_target();
    t_misc();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule